// File: doc/BRIEF.md
# Descriptor ring pointer controller

This block is the control core of a descriptor-driven bus master. Software fills entries in a circular ring of fixed-size transfer descriptors in memory. It then publishes how far it has filled by writing an 8-bit head index and setting a start bit. The controller keeps its own 8-bit tail index. It hands the entry at the tail to a transaction sequencer, one entry at a time, and moves the tail forward each time the sequencer reports that entry complete. The ring length is programmable as the entry count minus one, and the tail wraps back to zero after the last entry.

Software reaches all state through a small register window with 32-bit words at byte offsets. The base address is at 0x00 (low word) and 0x04 (high word). Control is at 0x08, status at 0x0C, ring size at 0x10 and bus timing at 0x14. Each completion reports whether it succeeded, whether the descriptor asked for an interrupt, and whether it asked to halt on error. Those three bits decide whether a pending flag is raised, whether the tail moves and whether the start bit drops. The pending flags are cleared by writing one to them. Their logical OR drives the interrupt output. The block also computes the memory address of the descriptor being issued and exports a 2-bit bus speed select.

Top module: `ring_ptr_ctrl`

## Requirements
- R1: After reset, control (0x08) reads 0, status (0x0C) reads 0, ring size (0x10) reads 31, timing (0x14) reads 0x40000000, and irq, disp_valid and bus_speed are 0, 0 and 1.
- R2: Base low/high (0x00/0x04) read back as written. Control keeps start in bit 0, error-interrupt enable in bit 4 and head in bits 23:16. Ring size keeps bits 7:0. Timing keeps bits 31:30. All other bits read 0.
- R3: When start is 1, the tail differs from the head and nothing is in progress, disp_valid pulses for exactly one cycle with disp_index equal to the tail. Status bit 0 then reads 1 until the completion arrives. No pulse occurs while tail equals head.
- R4: disp_addr equals the 64-bit base plus tail times 16.
- R5: A completion that is successful, or that did not request halt-on-error, advances the tail (status bits 23:16). The tail goes back to 0 after reaching the programmed size-minus-one value.
- R6: A completion with cmp_irq set raises status bit 5. The irq output is high while status bit 4 or bit 5 is 1.
- R7: Writing one to status bit 4 or bit 5 clears that bit. Writing zero leaves it unchanged. Writes to other status bits, including the tail field, have no effect.
- R8: A failed completion with cmp_soe set leaves the tail on the failing entry and clears start. It sets status bit 4 only if control bit 4 is 1.
- R9: When a completion raises status bit 5 in the same cycle that software writes one to clear it, the bit ends up 1.
- R10: Clearing start while a transfer is in progress lets that transfer complete and advance the tail, but no further entry is issued.
- R11: bus_speed equals timing bits 31:30 (0 = 80 kHz, 1 = 100 kHz, 2 = 400 kHz, 3 = 1 MHz).
- R12: A cmp_valid pulse while nothing is in progress changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| disp_valid | output | 1 | One-cycle pulse that issues a descriptor |
| disp_index | output | 8 | Ring index of the issued descriptor (the tail) |
| disp_addr | output | 64 | Memory address of the issued descriptor |
| cmp_valid | input | 1 | Sequencer reports completion of the issued descriptor |
| cmp_ok | input | 1 | Completion was successful |
| cmp_irq | input | 1 | Descriptor requested a completion interrupt |
| cmp_soe | input | 1 | Descriptor requested halt on error |
| irq | output | 1 | Interrupt request, OR of the pending flags |
| bus_speed | output | 2 | Bus speed select |

## Verification
The completion path and the software write port can both update the status pending flags in the same clock. The bench reproduces this by driving a completion with cmp_irq high in the same cycle as a status write that clears bit 5, and expects the flag to read 1 afterwards. A second overlap is a halt-on-error completion that clears start while start is still set in the control register. The bench judges it by reading control and checking that start is 0, and by confirming that no new dispatch pulse appears after the halt.

// File: rtl/ring_ptr_pkg.sv
package ring_ptr_pkg;

    localparam int REG_AW     = 8;
    localparam int PTR_W      = 8;
    localparam int BASE_W     = 64;
    localparam int DESC_BYTES = 16;

    localparam logic [REG_AW-1:0] OFS_BASE_LO = 8'h00;
    localparam logic [REG_AW-1:0] OFS_BASE_HI = 8'h04;
    localparam logic [REG_AW-1:0] OFS_CTRL    = 8'h08;
    localparam logic [REG_AW-1:0] OFS_STAT    = 8'h0C;
    localparam logic [REG_AW-1:0] OFS_SIZE    = 8'h10;
    localparam logic [REG_AW-1:0] OFS_TIMING  = 8'h14;

    typedef enum logic {
        ENG_IDLE = 1'b0,
        ENG_BUSY = 1'b1
    } eng_state_e;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic              start;
        logic              err_ie;
        logic [PTR_W-1:0]  head;
        logic [PTR_W-1:0]  size_m1;
        logic [1:0]        speed;
        logic              done_pend;
        logic              err_pend;
    } regs_t;

    typedef struct packed {
        eng_state_e        state;
        logic [PTR_W-1:0]  tail;
        logic              launch;
    } eng_t;

endpackage

// File: rtl/ring_ptr_regs.sv
module ring_ptr_regs
    import ring_ptr_pkg::*;
#(
    parameter logic [PTR_W-1:0] DEF_SIZE_M1 = 8'd31,
    parameter logic [1:0]       DEF_SPEED   = 2'd1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [REG_AW-1:0] addr_i,
    input  logic [31:0]       wdata_i,
    output logic [31:0]       rdata_o,
    input  logic [PTR_W-1:0]  tail_i,
    input  logic              busy_i,
    input  logic              ev_done_irq_i,
    input  logic              ev_err_i,
    input  logic              ev_halt_i,
    output logic [BASE_W-1:0] base_o,
    output logic              start_o,
    output logic [PTR_W-1:0]  head_o,
    output logic [PTR_W-1:0]  size_m1_o,
    output logic [1:0]        speed_o,
    output logic              irq_o
);

    regs_t q, d;

    always_comb begin
        d = q;
        if (wr_en_i) begin
            case (addr_i)
                OFS_BASE_LO: d.base[31:0]  = wdata_i;
                OFS_BASE_HI: d.base[63:32] = wdata_i;
                OFS_CTRL: begin
                    d.start  = wdata_i[0];
                    d.err_ie = wdata_i[4];
                    d.head   = wdata_i[23:16];
                end
                OFS_STAT: begin
                    if (wdata_i[4]) d.err_pend  = 1'b0;
                    if (wdata_i[5]) d.done_pend = 1'b0;
                end
                OFS_SIZE:   d.size_m1 = wdata_i[7:0];
                OFS_TIMING: d.speed   = wdata_i[31:30];
                default: ;
            endcase
        end
        // hardware events take priority over software writes
        if (ev_halt_i)                d.start     = 1'b0;
        if (ev_done_irq_i)            d.done_pend = 1'b1;
        if (ev_err_i && q.err_ie)     d.err_pend  = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{base: '0, start: 1'b0, err_ie: 1'b0, head: '0,
                   size_m1: DEF_SIZE_M1, speed: DEF_SPEED,
                   done_pend: 1'b0, err_pend: 1'b0};
        end else begin
            q <= d;
        end
    end

    always_comb begin
        case (addr_i)
            OFS_BASE_LO: rdata_o = q.base[31:0];
            OFS_BASE_HI: rdata_o = q.base[63:32];
            OFS_CTRL:    rdata_o = {8'h00, q.head, 11'h000, q.err_ie, 3'b000, q.start};
            OFS_STAT:    rdata_o = {8'h00, tail_i, 10'h000, q.done_pend, q.err_pend,
                                    3'b000, busy_i};
            OFS_SIZE:    rdata_o = {24'h000000, q.size_m1};
            OFS_TIMING:  rdata_o = {q.speed, 30'h00000000};
            default:     rdata_o = 32'h0;
        endcase
    end

    assign base_o    = q.base;
    assign start_o   = q.start;
    assign head_o    = q.head;
    assign size_m1_o = q.size_m1;
    assign speed_o   = q.speed;
    assign irq_o     = q.done_pend | q.err_pend;

    AST_HALT_CLEARS_START: assert property (@(posedge clk) disable iff (!rst_n)
        ev_halt_i |=> !q.start); // R8
    AST_ERR_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.err_pend) |-> $past(q.err_ie)); // R8
    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ev_done_irq_i |=> q.done_pend); // R9

endmodule

// File: rtl/ring_ptr_engine.sv
module ring_ptr_engine
    import ring_ptr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [PTR_W-1:0] head_i,
    input  logic [PTR_W-1:0] size_m1_i,
    input  logic             cmp_valid_i,
    input  logic             cmp_ok_i,
    input  logic             cmp_irq_i,
    input  logic             cmp_soe_i,
    output logic [PTR_W-1:0] tail_o,
    output logic             busy_o,
    output logic             launch_o,
    output logic             ev_done_irq_o,
    output logic             ev_err_o,
    output logic             ev_halt_o
);

    eng_t q, d;
    logic fail_stop;

    always_comb begin
        d             = q;
        d.launch      = 1'b0;
        ev_done_irq_o = 1'b0;
        ev_err_o      = 1'b0;
        ev_halt_o     = 1'b0;
        fail_stop     = !cmp_ok_i && cmp_soe_i;
        case (q.state)
            ENG_IDLE: begin
                if (start_i && (q.tail != head_i)) begin
                    d.state  = ENG_BUSY;
                    d.launch = 1'b1;
                end
            end
            ENG_BUSY: begin
                if (cmp_valid_i) begin
                    d.state       = ENG_IDLE;
                    ev_done_irq_o = cmp_irq_i;
                    if (fail_stop) begin
                        ev_err_o  = 1'b1;
                        ev_halt_o = 1'b1;
                    end else if (q.tail >= size_m1_i) begin
                        d.tail = '0;
                    end else begin
                        d.tail = q.tail + 1'b1;
                    end
                end
            end
            default: d.state = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: ENG_IDLE, tail: '0, launch: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign tail_o   = q.tail;
    assign busy_o   = (q.state == ENG_BUSY);
    assign launch_o = q.launch;

    AST_LAUNCH_HAS_WORK: assert property (@(posedge clk) disable iff (!rst_n)
        q.launch |-> $past(start_i && (q.tail != head_i) && q.state == ENG_IDLE)); // R3
    AST_LAUNCH_ENTERS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        q.launch |-> (q.state == ENG_BUSY) && !$past(q.state == ENG_BUSY)); // R3
    AST_TAIL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.tail) |-> (q.tail == $past(q.tail) + 1'b1) || (q.tail == '0)); // R5
    AST_HALT_KEEPS_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ENG_BUSY && cmp_valid_i && !cmp_ok_i && cmp_soe_i)
        |=> q.tail == $past(q.tail)); // R8
    AST_IDLE_CMP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ENG_IDLE && cmp_valid_i) |=> $stable(q.tail)); // R12

endmodule

// File: rtl/ring_ptr_addr.sv
module ring_ptr_addr
    import ring_ptr_pkg::*;
#(
    parameter int ENTRY_BYTES = DESC_BYTES
) (
    input  logic [BASE_W-1:0] base_i,
    input  logic [PTR_W-1:0]  tail_i,
    output logic [BASE_W-1:0] fetch_addr_o
);

    localparam int SHIFT = $clog2(ENTRY_BYTES);

    logic [BASE_W-1:0] offset;

    always_comb begin
        offset       = {{(BASE_W-PTR_W){1'b0}}, tail_i} << SHIFT;
        fetch_addr_o = base_i + offset;
    end

endmodule

// File: rtl/ring_ptr_ctrl.sv
module ring_ptr_ctrl
    import ring_ptr_pkg::*;
#(
    parameter logic [PTR_W-1:0] DEF_SIZE_M1 = 8'd31,
    parameter logic [1:0]       DEF_SPEED   = 2'd1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              disp_valid,
    output logic [PTR_W-1:0]  disp_index,
    output logic [BASE_W-1:0] disp_addr,
    input  logic              cmp_valid,
    input  logic              cmp_ok,
    input  logic              cmp_irq,
    input  logic              cmp_soe,
    output logic              irq,
    output logic [1:0]        bus_speed
);

    logic [PTR_W-1:0]  tail;
    logic              busy;
    logic              ev_done_irq;
    logic              ev_err;
    logic              ev_halt;
    logic [BASE_W-1:0] base;
    logic              start;
    logic [PTR_W-1:0]  head;
    logic [PTR_W-1:0]  size_m1;

    ring_ptr_regs #(
        .DEF_SIZE_M1 (DEF_SIZE_M1),
        .DEF_SPEED   (DEF_SPEED)
    ) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en_i       (reg_wr_en),
        .addr_i        (reg_addr),
        .wdata_i       (reg_wdata),
        .rdata_o       (reg_rdata),
        .tail_i        (tail),
        .busy_i        (busy),
        .ev_done_irq_i (ev_done_irq),
        .ev_err_i      (ev_err),
        .ev_halt_i     (ev_halt),
        .base_o        (base),
        .start_o       (start),
        .head_o        (head),
        .size_m1_o     (size_m1),
        .speed_o       (bus_speed),
        .irq_o         (irq)
    );

    ring_ptr_engine u_engine (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start),
        .head_i        (head),
        .size_m1_i     (size_m1),
        .cmp_valid_i   (cmp_valid),
        .cmp_ok_i      (cmp_ok),
        .cmp_irq_i     (cmp_irq),
        .cmp_soe_i     (cmp_soe),
        .tail_o        (tail),
        .busy_o        (busy),
        .launch_o      (disp_valid),
        .ev_done_irq_o (ev_done_irq),
        .ev_err_o      (ev_err),
        .ev_halt_o     (ev_halt)
    );

    ring_ptr_addr u_addr (
        .base_i       (base),
        .tail_i       (tail),
        .fetch_addr_o (disp_addr)
    );

    assign disp_index = tail;

    AST_IRQ_FROM_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(ev_done_irq || ev_err)); // R6

endmodule

// File: tb/ring_ptr_ctrl_tb.sv
module ring_ptr_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [7:0]  reg_addr = 8'h0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        disp_valid;
    logic [7:0]  disp_index;
    logic [63:0] disp_addr;
    logic        cmp_valid = 1'b0;
    logic        cmp_ok = 1'b0;
    logic        cmp_irq = 1'b0;
    logic        cmp_soe = 1'b0;
    logic        irq;
    logic [1:0]  bus_speed;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    localparam logic [63:0] BASE = 64'h0000_0012_3456_7800;

    always #4 clk = ~clk;

    ring_ptr_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .disp_valid(disp_valid),
        .disp_index(disp_index), .disp_addr(disp_addr), .cmp_valid(cmp_valid),
        .cmp_ok(cmp_ok), .cmp_irq(cmp_irq), .cmp_soe(cmp_soe), .irq(irq),
        .bus_speed(bus_speed)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic chk_reg(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        reg_read(a, v);
        chk(req, {32'h0, v}, {32'h0, exp});
    endtask

    task automatic expect_launch(input string req, input logic [7:0] idx);
        @(negedge clk);
        chk({req, " disp_valid"}, {63'h0, disp_valid}, 64'h1);
        chk({req, " disp_index"}, {56'h0, disp_index}, {56'h0, idx});
        chk({req, " disp_addr"}, disp_addr, BASE + 64'(idx) * 64'd16);
    endtask

    task automatic expect_quiet(input string req);
        @(negedge clk);
        chk({req, " no dispatch"}, {63'h0, disp_valid}, 64'h0);
    endtask

    task automatic complete(input logic ok, input logic irqf, input logic soe);
        @(negedge clk);
        cmp_valid = 1'b1; cmp_ok = ok; cmp_irq = irqf; cmp_soe = soe;
        @(negedge clk);
        cmp_valid = 1'b0; cmp_ok = 1'b0; cmp_irq = 1'b0; cmp_soe = 1'b0;
    endtask

    task automatic t_reset;
        chk_reg("R1 ctrl", 8'h08, 32'h0);
        chk_reg("R1 status", 8'h0C, 32'h0);
        chk_reg("R1 size", 8'h10, 32'd31);
        chk_reg("R1 timing", 8'h14, 32'h4000_0000);
        chk("R1 irq", {63'h0, irq}, 64'h0);
        chk("R1 disp_valid", {63'h0, disp_valid}, 64'h0);
        chk("R1 bus_speed", {62'h0, bus_speed}, 64'h1);
    endtask

    task automatic t_regs;
        reg_write(8'h00, BASE[31:0]);
        reg_write(8'h04, BASE[63:32]);
        chk_reg("R2 base lo", 8'h00, BASE[31:0]);
        chk_reg("R2 base hi", 8'h04, BASE[63:32]);
        reg_write(8'h08, 32'hFFFF_FFFE);
        chk_reg("R2 ctrl mask", 8'h08, 32'h00FF_0010);
        reg_write(8'h08, 32'h0);
        reg_write(8'h10, 32'hFFFF_FF07);
        chk_reg("R2 size mask", 8'h10, 32'h07);
        reg_write(8'h10, 32'd31);
        reg_write(8'h14, 32'hFFFF_FFFF);
        chk_reg("R2 timing mask", 8'h14, 32'hC000_0000);
        chk("R11 speed 3", {62'h0, bus_speed}, 64'h3);
        reg_write(8'h14, 32'h8000_0000);
        chk("R11 speed 2", {62'h0, bus_speed}, 64'h2);
    endtask

    task automatic t_dispatch;
        reg_write(8'h08, 32'h0002_0001);
        expect_launch("R3 R4 first", 8'd0);
        @(negedge clk);
        chk("R3 one-cycle pulse", {63'h0, disp_valid}, 64'h0);
        chk_reg("R3 in progress", 8'h0C, 32'h0000_0001);
        complete(1'b1, 1'b0, 1'b0);
        chk_reg("R5 tail 1", 8'h0C, 32'h0001_0000);
        expect_launch("R4 second", 8'd1);
        complete(1'b1, 1'b1, 1'b0);
        chk_reg("R6 done pending", 8'h0C, 32'h0002_0020);
        chk("R6 irq high", {63'h0, irq}, 64'h1);
        expect_quiet("R3 empty ring");
    endtask

    task automatic t_w1c;
        reg_write(8'h0C, 32'hFFFF_FFCF);
        chk_reg("R7 zero write ignored", 8'h0C, 32'h0002_0020);
        reg_write(8'h0C, 32'h0000_0020);
        chk_reg("R7 w1c clears", 8'h0C, 32'h0002_0000);
        chk("R7 irq low", {63'h0, irq}, 64'h0);
    endtask

    task automatic t_wrap;
        reg_write(8'h10, 32'd3);
        reg_write(8'h08, 32'h0001_0001);
        expect_launch("R5 idx2", 8'd2);
        complete(1'b1, 1'b0, 1'b0);
        expect_launch("R5 idx3", 8'd3);
        complete(1'b1, 1'b0, 1'b0);
        expect_launch("R5 wrap idx0", 8'd0);
        complete(1'b1, 1'b0, 1'b0);
        expect_quiet("R5 after wrap");
        chk_reg("R5 tail after wrap", 8'h0C, 32'h0001_0000);
    endtask

    task automatic t_same_cycle;
        reg_write(8'h08, 32'h0002_0001);
        expect_launch("R9 idx1", 8'd1);
        reg_wr_en = 1'b1; reg_addr = 8'h0C; reg_wdata = 32'h20;
        cmp_valid = 1'b1; cmp_ok = 1'b1; cmp_irq = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0; cmp_valid = 1'b0; cmp_ok = 1'b0; cmp_irq = 1'b0;
        chk_reg("R9 set wins", 8'h0C, 32'h0002_0020);
        reg_write(8'h0C, 32'h20);
    endtask

    task automatic t_halt;
        reg_write(8'h08, 32'h0000_0001);
        expect_launch("R8 idx2", 8'd2);
        complete(1'b0, 1'b0, 1'b1);
        chk_reg("R8 tail held, no err", 8'h0C, 32'h0002_0000);
        chk_reg("R8 start cleared", 8'h08, 32'h0);
        chk("R8 irq low", {63'h0, irq}, 64'h0);
        expect_quiet("R8 halted");
        reg_write(8'h08, 32'h0000_0011);
        expect_launch("R8 retry idx2", 8'd2);
        complete(1'b0, 1'b0, 1'b1);
        chk_reg("R8 err pending", 8'h0C, 32'h0002_0010);
        chk_reg("R8 start cleared again", 8'h08, 32'h0000_0010);
        chk("R8 irq high", {63'h0, irq}, 64'h1);
        reg_write(8'h0C, 32'h10);
        chk_reg("R7 err cleared", 8'h0C, 32'h0002_0000);
        reg_write(8'h08, 32'h0000_0011);
        expect_launch("R5 fail no soe idx2", 8'd2);
        complete(1'b0, 1'b0, 1'b0);
        expect_launch("R5 advance past failure", 8'd3);
        complete(1'b1, 1'b0, 1'b0);
        expect_quiet("R5 head reached");
        chk_reg("R8 no err without soe", 8'h0C, 32'h0);
    endtask

    task automatic t_stop;
        reg_write(8'h08, 32'h0002_0001);
        expect_launch("R10 idx0", 8'd0);
        reg_write(8'h08, 32'h0002_0000);
        chk_reg("R10 still in progress", 8'h0C, 32'h0000_0001);
        complete(1'b1, 1'b0, 1'b0);
        expect_quiet("R10 stopped");
        expect_quiet("R10 stopped later");
        chk_reg("R10 tail advanced", 8'h0C, 32'h0001_0000);
    endtask

    task automatic t_idle_cmp;
        complete(1'b1, 1'b1, 1'b0);
        chk_reg("R12 idle completion ignored", 8'h0C, 32'h0001_0000);
        chk("R12 irq low", {63'h0, irq}, 64'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_regs;
        t_dispatch;
        t_w1c;
        t_wrap;
        t_same_cycle;
        t_halt;
        t_stop;
        t_idle_cmp;
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule